// File: doc/BRIEF.md
# GPIO Interrupt Channel Router

This block turns a wide bank of general-purpose input pins into a small set of interrupt lines. Each of twelve interrupt channels picks one of 82 pins through its own 8-bit select field. The chosen pin is then conditioned by one of five trigger rules: active-high level, active-low level, rising edge, falling edge, or any edge. Each channel drives one interrupt output.

Every pin first passes through a two-flop synchroniser. Software sets up the channels through a word-addressed write/read port with eight registers. One master bit gates every channel at once. Edge triggers give single-clock pulses. Level triggers hold their output for as long as the pin stays at its active level.

Register layout (word address: content):
- Word 0: bit 31 is the master enable. Bits 23:12 are the edge-sense bits, one per channel, with channel n at bit 12+n. Bits 11:0 are the low-polarity bits, with channel n at bit n.
- Words 1 to 6: word k holds the select for channel 2k−2 in bits 7:0 and the select for channel 2k−1 in bits 23:16.
- Word 7: bits 11:0 are the any-edge bits, with channel n at bit n.

Top module: `gpio_irq_router`

## Requirements
- R1: Reset clears every register, so every word reads 0, and drives irq_out to all zeros.
- R2: A read returns the stored value with all undefined bits forced to zero. After writing all ones, the words read back as follows: word 0 gives 0x80FFFFFF, words 1 to 6 give 0x00FF00FF, and word 7 gives 0x00000FFF.
- R3: While word 0 bit 31 is clear, every irq_out bit is 0 in the cycle after.
- R4: In word k (1 to 6), bits 7:0 route pin[value] to channel 2k−2 and bits 23:16 route pin[value] to channel 2k−1.
- R5: A select value of 82 or more makes its channel never fire, whatever its trigger settings are.
- R6: With the edge-sense bit, the low-polarity bit and the any-edge bit all clear, the channel output equals the synchronised pin level.
- R7: With the edge-sense bit and the any-edge bit clear and the low-polarity bit set, the output is the inverted synchronised pin level.
- R8: With the edge-sense bit set, the low-polarity bit clear and the any-edge bit clear, a 0→1 pin change gives a one-clock pulse, and a 1→0 change gives none.
- R9: With the edge-sense bit and the low-polarity bit set and the any-edge bit clear, a 1→0 pin change gives a one-clock pulse, and a 0→1 change gives none.
- R10: With the any-edge bit (word 7) set, either pin transition gives a one-clock pulse. The edge-sense and low-polarity bits have no effect in this case.
- R11: A pin change reaches the output on the third rising clock edge after it is applied: two synchroniser stages, then the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address for both reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| gpio_in | input | 82 | Asynchronous pin inputs |
| irq_out | output | 12 | One interrupt line per channel |

## Verification
The pulse-shape and any-edge assertions assume that a channel's configuration (select, polarity, mode bits) holds steady across the two cycles they examine. Their antecedents require this stability explicitly. The bench only reconfigures a channel and then lets several idle cycles pass before it moves a pin. It changes a pin at most once every four cycles, so no pulse ever abuts the next pulse. The bench drives pins and register writes on falling clock edges, which keeps every input away from the sampling edge.

// File: rtl/girq_pkg.sv
package girq_pkg;

  localparam int unsigned GIRQ_MASTER_BIT = 31;
  localparam int unsigned GIRQ_EDGE_LSB   = 12;
  localparam int unsigned GIRQ_HI_SEL_LSB = 16;

  // Trigger decision for one channel from the current and previous pin sample.
  function automatic logic girq_fire(input logic cur, input logic prev,
                                     input logic edge_sense, input logic pol_low,
                                     input logic any_edge);
    if (any_edge)   return cur ^ prev;
    if (edge_sense) return pol_low ? (prev & ~cur) : (cur & ~prev);
    return pol_low ? ~cur : cur;
  endfunction

  // Mask of the bits a register word actually stores.
  function automatic logic [31:0] girq_word_mask(input int unsigned idx,
                                                 input int unsigned n_ch,
                                                 input int unsigned n_words,
                                                 input int unsigned sel_w);
    logic [31:0] m;
    m = '0;
    if (idx == 0) begin
      m[GIRQ_MASTER_BIT] = 1'b1;
      for (int unsigned b = 0; b < n_ch; b++) begin
        m[b] = 1'b1;
        m[GIRQ_EDGE_LSB + b] = 1'b1;
      end
    end else if (idx == n_words - 1) begin
      for (int unsigned b = 0; b < n_ch; b++) m[b] = 1'b1;
    end else if (idx < n_words - 1) begin
      for (int unsigned b = 0; b < sel_w; b++) begin
        m[b] = 1'b1;
        m[GIRQ_HI_SEL_LSB + b] = 1'b1;
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/girq_sync.sv
module girq_sync #(
  parameter int unsigned W = 82
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/girq_regs.sv
module girq_regs
  import girq_pkg::*;
#(
  parameter int unsigned N_CH    = 12,
  parameter int unsigned SEL_W   = 8,
  parameter int unsigned N_WORDS = 8,
  parameter int unsigned AW      = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [AW-1:0]              addr,
  input  logic [31:0]                wdata,
  output logic [31:0]                rdata,
  output logic                       master_en,
  output logic [N_CH-1:0]            edge_sense,
  output logic [N_CH-1:0]            pol_low,
  output logic [N_CH-1:0]            any_edge,
  output logic [N_CH-1:0][SEL_W-1:0] sel
);
  localparam int unsigned N_SLOTS = 2 ** AW;

  logic [31:0] word_q [N_SLOTS];

  for (genvar w = 0; w < N_SLOTS; w++) begin : g_word
    localparam logic [31:0] MASK = girq_word_mask(w, N_CH, N_WORDS, SEL_W);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q[w] <= '0;
      else if (wr && addr == AW'(w)) word_q[w] <= wdata & MASK;
    end
  end

  assign rdata      = word_q[addr];
  assign master_en  = word_q[0][GIRQ_MASTER_BIT];
  assign pol_low    = word_q[0][N_CH-1:0];
  assign edge_sense = word_q[0][GIRQ_EDGE_LSB +: N_CH];
  assign any_edge   = word_q[N_WORDS-1][N_CH-1:0];

  for (genvar c = 0; c < N_CH; c++) begin : g_sel
    localparam int unsigned WORD = c / 2 + 1;
    localparam int unsigned LSB  = (c % 2) * GIRQ_HI_SEL_LSB;
    assign sel[c] = word_q[WORD][LSB +: SEL_W];
  end

  // R2: undefined bits never appear on the read port
  assert_rd_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~girq_word_mask(32'(addr), N_CH, N_WORDS, SEL_W)) == 32'd0);
endmodule

// File: rtl/girq_channel.sv
module girq_channel
  import girq_pkg::*;
#(
  parameter int unsigned N_PINS = 82,
  parameter int unsigned SEL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pins,
  input  logic [SEL_W-1:0]  sel,
  input  logic              master_en,
  input  logic              edge_sense,
  input  logic              pol_low,
  input  logic              any_edge,
  output logic              irq
);
  logic sel_ok;
  logic cur;
  logic prev_q;
  logic hit;
  logic irq_q;

  assign sel_ok = (32'(sel) < N_PINS);
  assign cur    = sel_ok ? pins[sel] : 1'b0;
  assign hit    = girq_fire(cur, prev_q, edge_sense, pol_low, any_edge);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= cur;
      irq_q  <= master_en & sel_ok & hit;
    end
  end

  assign irq = irq_q;

  // R5: an out-of-range select keeps the channel silent
  assert_bad_sel_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ok |=> !irq);

  // R8/R9: single-edge mode with steady configuration never gives back-to-back pulses
  assert_one_clk_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && edge_sense && !any_edge && $past(edge_sense) && !$past(any_edge)
     && $stable(pol_low) && $stable(sel)) |=> !irq);

  // R10: any-edge mode fires on every change of the routed pin
  assert_any_edge_fires_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (any_edge && master_en && sel_ok && (cur != prev_q)) |=> irq);
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import girq_pkg::*;
#(
  parameter int unsigned N_PINS = 82,
  parameter int unsigned N_CH   = 12,
  parameter int unsigned SEL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [N_PINS-1:0] gpio_in,
  output logic [N_CH-1:0]   irq_out
);
  localparam int unsigned N_WORDS = (N_CH + 1) / 2 + 2;
  localparam int unsigned AW      = $clog2(N_WORDS);

  logic [N_PINS-1:0]          pins_s;
  logic                       master_en;
  logic [N_CH-1:0]            edge_sense;
  logic [N_CH-1:0]            pol_low;
  logic [N_CH-1:0]            any_edge;
  logic [N_CH-1:0][SEL_W-1:0] sel;

  girq_sync #(.W(N_PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (gpio_in),
    .sync_out (pins_s)
  );

  girq_regs #(.N_CH(N_CH), .SEL_W(SEL_W), .N_WORDS(N_WORDS), .AW(AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .master_en  (master_en),
    .edge_sense (edge_sense),
    .pol_low    (pol_low),
    .any_edge   (any_edge),
    .sel        (sel)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    girq_channel #(.N_PINS(N_PINS), .SEL_W(SEL_W)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .pins       (pins_s),
      .sel        (sel[c]),
      .master_en  (master_en),
      .edge_sense (edge_sense[c]),
      .pol_low    (pol_low[c]),
      .any_edge   (any_edge[c]),
      .irq        (irq_out[c])
    );
  end

  // R3: master enable low silences every channel on the next edge
  assert_master_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |=> (irq_out == '0));
endmodule

// File: tb/test_gpio_irq_router.sv
module test_gpio_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [81:0] gpio = '0;
  logic [11:0] irq_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_router i_gpio_irq_router (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .gpio_in   (gpio),
    .irq_out   (irq_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_word(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = 3'(a);
    #1;
    chk(reg_rdata === exp, $sformatf("%s word%0d", tag, a), reg_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // mode: 0 level high, 1 level low, 2 rising, 3 falling, 4 any edge
  function automatic bit exp_early(input int mode, input bit v);
    if (mode == 0) return !v;
    if (mode == 1) return v;
    return 1'b0;
  endfunction

  function automatic bit exp_first(input int mode, input bit v);
    case (mode)
      0: return v;
      1: return !v;
      2: return v;
      3: return !v;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit exp_second(input int mode, input bit v);
    if (mode == 0) return v;
    if (mode == 1) return !v;
    return 1'b0;
  endfunction

  function automatic string mode_tag(input int mode);
    case (mode)
      0: return "R6";
      1: return "R7";
      2: return "R8";
      3: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic run_case(input int ch, input int pin, input int mode);
    logic [31:0] w0;
    logic [31:0] w7;
    logic [31:0] ws;
    bit es;
    bit pl;
    es = (mode >= 2);
    pl = (mode == 1 || mode == 3 || (mode == 4 && ch % 2 == 1));
    w0 = 32'h8000_0000 | (32'(es) << (12 + ch)) | (32'(pl) << ch);
    w7 = (mode == 4) ? (32'd1 << ch) : 32'd0;
    ws = (ch % 2 == 0) ? {8'h00, 8'hFF, 8'h00, 8'(pin)} : {8'h00, 8'(pin), 8'h00, 8'hFF};
    @(negedge clk);
    gpio = '0;
    wr_word(0, w0);
    wr_word(7, w7);
    wr_word(ch / 2 + 1, ws);
    idle(5);
    for (int t = 0; t < 2; t++) begin
      bit v;
      logic [11:0] e;
      v = (t == 0);
      gpio[pin] = v;
      idle(2);
      e = 12'(exp_early(mode, v)) << ch;
      chk(irq_out === e, $sformatf("R11 early ch%0d pin%0d mode%0d", ch, pin, mode), 32'(irq_out), 32'(e));
      idle(1);
      e = 12'(exp_first(mode, v)) << ch;
      chk(irq_out === e, $sformatf("R4/%s first ch%0d pin%0d", mode_tag(mode), ch, pin), 32'(irq_out), 32'(e));
      idle(1);
      e = 12'(exp_second(mode, v)) << ch;
      chk(irq_out === e, $sformatf("R4/%s second ch%0d pin%0d", mode_tag(mode), ch, pin), 32'(irq_out), 32'(e));
    end
    wr_word(ch / 2 + 1, 32'h00FF_00FF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(irq_out === 12'd0, "R1 irq after reset", 32'(irq_out), 32'd0);
    for (int a = 0; a < 8; a++) rd_chk(a, 32'd0, "R1");

    // R2: read-back masks
    for (int a = 0; a < 8; a++) wr_word(a, 32'hFFFF_FFFF);
    rd_chk(0, 32'h80FF_FFFF, "R2");
    for (int a = 1; a < 7; a++) rd_chk(a, 32'h00FF_00FF, "R2");
    rd_chk(7, 32'h0000_0FFF, "R2");

    // R1: reset clears written registers
    @(negedge clk);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) rd_chk(a, 32'd0, "R1 re-reset");

    // park all selects out of range
    for (int a = 1; a < 7; a++) wr_word(a, 32'h00FF_00FF);

    // sweep channels, pins and trigger modes
    for (int ch = 0; ch < 12; ch++) begin
      for (int k = 0; k < 2; k++) begin
        int pin;
        pin = (k == 0) ? ((ch == 0) ? 0 : (ch * 7 + 3) % 82) : 81 - ch;
        for (int mode = 0; mode < 5; mode++) run_case(ch, pin, mode);
      end
    end

    // R5: out-of-range selects with active-low level would fire if routed
    wr_word(0, 32'h8000_0FFF);
    wr_word(7, 32'd0);
    gpio = '0;
    wr_word(1, {8'h00, 8'd82, 8'h00, 8'hFF});
    idle(5);
    chk(irq_out === 12'd0, "R5 select 82/255", 32'(irq_out), 32'd0);
    wr_word(1, {8'h00, 8'd81, 8'h00, 8'd82});
    idle(5);
    chk(irq_out === 12'h002, "R5 select 81 fires ch1, 82 silent ch0", 32'(irq_out), 32'h002);

    // R3: master off blocks level-high channel with pin high
    wr_word(1, 32'h00FF_0005);
    wr_word(0, 32'h0000_0000);
    @(negedge clk);
    gpio[5] = 1'b1;
    idle(5);
    chk(irq_out === 12'd0, "R3 master off", 32'(irq_out), 32'd0);
    wr_word(0, 32'h8000_0000);
    idle(4);
    chk(irq_out === 12'h001, "R3 master on", 32'(irq_out), 32'h001);
    wr_word(0, 32'h0000_0000);
    idle(1);
    chk(irq_out === 12'd0, "R3 master off again", 32'(irq_out), 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule